// File: doc/BRIEF.md
# Three-Bus Register Datapath

This block is the data section of a small processor. A register file with two read ports and one write port sits between three buses. Bus A carries the first operand from read port A. Bus B carries the second operand, picked from read port B, the program counter, the memory data register or a constant zero. The ALU combines the two and drives bus C. In the same clock cycle, bus C can be written into any register, the memory address register, the instruction register or the program counter.

There are no staging registers in front of or behind the ALU. A three-register operation therefore completes in one step. A separate incrementer moves the program counter forward by four, so instruction fetch does not need the ALU for that.

Every control line is a primary input, driven by an external sequencer. Memory reads use a request/complete handshake. A read is started from the control inputs. The address comes from the memory address register, and the data is captured into the memory data register when the memory signals completion.

Top module: `tri_bus_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, every register, the program counter, the address, instruction and memory data registers are cleared to zero, and `mem_req_o` is low after that edge.
- R2: `rf_ra_a` and `rf_ra_b` read two registers in the same cycle onto buses A and B. The ALU result appears on `bus_c_o` combinationally, in that same cycle.
- R3: With `rf_we` high, register `rf_wa` takes the bus C value at the clock edge. With `rf_we` low, no register changes. A read of the register being written, in the same cycle, returns the value it held before the edge.
- R4: `alu_op` encodings are 0 A+B, 1 A−B, 2 A&B, 3 A|B, 4 A^B, 5 pass A, 6 pass B and 7 zero. Arithmetic wraps modulo 2^16.
- R5: `b_sel` encodings for bus B are 0 read port B, 1 program counter, 2 memory data register and 3 zero.
- R6: With `pc_inc` high, the program counter adds 4 at the edge. With `pc_load` high, it takes bus C instead, and `pc_load` wins when both are high.
- R7: `mar_load` and `ir_load` capture bus C into the address and instruction registers at the edge. Otherwise these registers hold. `mem_addr_o` shows the address register.
- R8: A high `ctl_read` at an edge raises `mem_req_o` from the next cycle. The request stays high until a cycle with `mem_mfc` high. At that edge the memory data register takes `mem_rdata` and the request drops. A `mem_mfc` with no request pending is ignored.
- R9: A fetch takes three control steps plus any memory wait. The steps are: PC passed through B into MAR with a read and an increment; wait for completion; then MDR passed through B into IR. A three-register add needs one step, even when the destination is also a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_ra_a | input | 3 | Register read address, bus A |
| rf_ra_b | input | 3 | Register read address, bus B port |
| rf_wa | input | 3 | Register write address |
| rf_we | input | 1 | Register write enable |
| b_sel | input | 2 | Bus B source select |
| alu_op | input | 3 | ALU operation |
| mar_load | input | 1 | Load address register from bus C |
| ir_load | input | 1 | Load instruction register from bus C |
| pc_load | input | 1 | Load program counter from bus C |
| pc_inc | input | 1 | Advance program counter by 4 |
| ctl_read | input | 1 | Start a memory read |
| mem_mfc | input | 1 | Memory read complete |
| mem_rdata | input | 16 | Memory read data |
| mem_req_o | output | 1 | Memory read pending |
| mem_addr_o | output | 16 | Memory address |
| bus_c_o | output | 16 | Bus C (ALU result) |
| pc_o | output | 16 | Program counter |
| ir_o | output | 16 | Instruction register |

## Verification
Bus C is combinational, so it is compared in the same cycle in which its controls are applied. The program counter, the address, instruction and memory data registers, and the register file change at the next edge. The bench therefore checks them at the start of the following step, reading registers back through pass-through operations. The memory model completes a read two cycles after it first sees the request. The request is checked high on both wait cycles and low in the cycle where the captured data is first used. Every expectation is queued together with the cycle it is due in, and the monitor compares it shortly after the falling clock edge.

// File: rtl/dp_pkg.sv
package dp_pkg;

    localparam int PC_STEP = 4;

    typedef enum logic [2:0] {
        ALU_ADD    = 3'd0,
        ALU_SUB    = 3'd1,
        ALU_AND    = 3'd2,
        ALU_OR     = 3'd3,
        ALU_XOR    = 3'd4,
        ALU_PASS_A = 3'd5,
        ALU_PASS_B = 3'd6,
        ALU_ZERO   = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        BSRC_RF   = 2'd0,
        BSRC_PC   = 2'd1,
        BSRC_MDR  = 2'd2,
        BSRC_ZERO = 2'd3
    } bsrc_e;

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    localparam int RA_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RA_W-1:0]   ra_a,
    input  logic [RA_W-1:0]   ra_b,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    input  logic              we,
    input  logic [RA_W-1:0]   wa,
    input  logic [DATA_W-1:0] wd
);
    logic [DATA_W-1:0] cells [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[i] <= '0;
            else if (we && (wa == RA_W'(i)))
                cells[i] <= wd;
        end
    end

    // Reads see the stored value; a write lands only at the edge.
    assign rd_a = cells[ra_a];
    assign rd_b = cells[ra_b];
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        case (alu_op_e'(op))
            ALU_ADD:    y = a + b;
            ALU_SUB:    y = a - b;
            ALU_AND:    y = a & b;
            ALU_OR:     y = a | b;
            ALU_XOR:    y = a ^ b;
            ALU_PASS_A: y = a;
            ALU_PASS_B: y = b;
            default:    y = '0;
        endcase
    end
endmodule

// File: rtl/dp_pc_unit.sv
module dp_pc_unit
    import dp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              inc,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] pc
);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(PC_STEP);

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else if (load)
            pc <= load_val;
        else if (inc)
            pc <= pc + STEP;
    end
endmodule

// File: rtl/tri_bus_datapath.sv
module tri_bus_datapath
    import dp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    localparam int RA_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RA_W-1:0]   rf_ra_a,
    input  logic [RA_W-1:0]   rf_ra_b,
    input  logic [RA_W-1:0]   rf_wa,
    input  logic              rf_we,
    input  logic [1:0]        b_sel,
    input  logic [2:0]        alu_op,
    input  logic              mar_load,
    input  logic              ir_load,
    input  logic              pc_load,
    input  logic              pc_inc,
    input  logic              ctl_read,
    input  logic              mem_mfc,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req_o,
    output logic [DATA_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] bus_c_o,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] ir_o
);
    logic [DATA_W-1:0] bus_a, bus_b, bus_c, rf_port_b;
    logic [DATA_W-1:0] pc_q, mar_q, ir_q, mdr_q;
    logic              pend_q;

    dp_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (rf_ra_a),
        .ra_b (rf_ra_b),
        .rd_a (bus_a),
        .rd_b (rf_port_b),
        .we   (rf_we),
        .wa   (rf_wa),
        .wd   (bus_c)
    );

    always_comb begin
        case (bsrc_e'(b_sel))
            BSRC_RF:  bus_b = rf_port_b;
            BSRC_PC:  bus_b = pc_q;
            BSRC_MDR: bus_b = mdr_q;
            default:  bus_b = '0;
        endcase
    end

    dp_alu #(.DATA_W(DATA_W)) u_alu (
        .op (alu_op),
        .a  (bus_a),
        .b  (bus_b),
        .y  (bus_c)
    );

    dp_pc_unit #(.DATA_W(DATA_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .load     (pc_load),
        .inc      (pc_inc),
        .load_val (bus_c),
        .pc       (pc_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q  <= '0;
            ir_q   <= '0;
            mdr_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (mar_load) mar_q <= bus_c;
            if (ir_load)  ir_q  <= bus_c;
            if (pend_q && mem_mfc) mdr_q <= mem_rdata;
            if (ctl_read)
                pend_q <= 1'b1;
            else if (mem_mfc)
                pend_q <= 1'b0;
        end
    end

    assign mem_req_o  = pend_q;
    assign mem_addr_o = mar_q;
    assign bus_c_o    = bus_c;
    assign pc_o       = pc_q;
    assign ir_o       = ir_q;
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              pc_inc,
    input logic              pc_load,
    input logic              ir_load,
    input logic              mar_load,
    input logic              ctl_read,
    input logic              mem_mfc,
    input logic [1:0]        b_sel,
    input logic [2:0]        alu_op,
    input logic              mem_req_o,
    input logic [DATA_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] bus_c_o,
    input logic [DATA_W-1:0] pc_o,
    input logic [DATA_W-1:0] ir_o,
    input logic [DATA_W-1:0] mdr_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && ir_o == '0 && mem_addr_o == '0 && !mem_req_o)); // R1

    AST_PASS_PC: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 3'd6 && b_sel == 2'd1) |-> bus_c_o == pc_o); // R5

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (pc_inc && !pc_load) |=> pc_o == $past(pc_o) + DATA_W'(4)); // R6

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> pc_o == $past(bus_c_o)); // R6

    AST_IR_LOAD: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> ir_o == $past(bus_c_o)); // R7

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ir_load |=> $stable(ir_o)); // R7

    AST_MAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mar_load |=> $stable(mem_addr_o)); // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_mfc) |=> mem_req_o); // R8

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_mfc && !ctl_read) |=> !mem_req_o); // R8

    AST_MDR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(mem_req_o && mem_mfc) |=> $stable(mdr_q)); // R8
endmodule

bind tri_bus_datapath dp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_inc     (pc_inc),
    .pc_load    (pc_load),
    .ir_load    (ir_load),
    .mar_load   (mar_load),
    .ctl_read   (ctl_read),
    .mem_mfc    (mem_mfc),
    .b_sel      (b_sel),
    .alu_op     (alu_op),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .bus_c_o    (bus_c_o),
    .pc_o       (pc_o),
    .ir_o       (ir_o),
    .mdr_q      (mdr_q)
);

// File: tb/tb_tri_bus_datapath.sv
`timescale 1ns/1ps
module tb_tri_bus_datapath;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] rf_ra_a, rf_ra_b, rf_wa, alu_op;
    logic [1:0] b_sel;
    logic rf_we, mar_load, ir_load, pc_load, pc_inc, ctl_read;
    logic mem_mfc;
    logic [W-1:0] mem_rdata;
    logic mem_req_o;
    logic [W-1:0] mem_addr_o, bus_c_o, pc_o, ir_o;

    logic model_mfc = 1'b0, stray_mfc = 1'b0;
    logic [W-1:0] model_data = '0;
    int unsigned mem_cnt = 0;

    assign mem_mfc   = model_mfc | stray_mfc;
    assign mem_rdata = stray_mfc ? 16'hDEAD : model_data;

    always #2 clk = ~clk;

    tri_bus_datapath dut (
        .clk(clk), .rst(rst), .rf_ra_a(rf_ra_a), .rf_ra_b(rf_ra_b), .rf_wa(rf_wa),
        .rf_we(rf_we), .b_sel(b_sel), .alu_op(alu_op), .mar_load(mar_load),
        .ir_load(ir_load), .pc_load(pc_load), .pc_inc(pc_inc), .ctl_read(ctl_read),
        .mem_mfc(mem_mfc), .mem_rdata(mem_rdata), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .bus_c_o(bus_c_o), .pc_o(pc_o), .ir_o(ir_o)
    );

    function automatic logic [W-1:0] mem_word(input logic [W-1:0] a);
        return (a * 16'h0101) ^ 16'h5A3C;
    endfunction

    // Memory model: completes two cycles after it first sees the request.
    always @(negedge clk) begin
        model_mfc = 1'b0;
        if (mem_req_o && !rst) begin
            if (mem_cnt == 1) begin
                model_mfc  = 1'b1;
                model_data = mem_word(mem_addr_o);
                mem_cnt    = 0;
            end else begin
                mem_cnt = mem_cnt + 1;
            end
        end
    end

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef enum int { K_BUSC, K_PC, K_IR, K_ADDR, K_REQ } kind_e;
    typedef struct {
        kind_e        kind;
        logic [W-1:0] exp;
        int unsigned  due;
        string        tag;
    } item_t;
    item_t sb[$];

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    logic [W-1:0] m_pc = '0, m_ir = '0, m_mdr = '0;
    logic [W-1:0] m_reg [8];

    task automatic push(input kind_e k, input logic [W-1:0] e, input string tag);
        item_t it;
        it.kind = k; it.exp = e; it.due = cyc; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares queued items after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                logic [W-1:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_BUSC:  act = bus_c_o;
                    K_PC:    act = pc_o;
                    K_IR:    act = ir_o;
                    K_ADDR:  act = mem_addr_o;
                    default: act = {15'd0, mem_req_o};
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic idle();
        rf_ra_a = '0; rf_ra_b = '0; rf_wa = '0; rf_we = 0; b_sel = 2'd0;
        alu_op = 3'd7; mar_load = 0; ir_load = 0; pc_load = 0; pc_inc = 0;
        ctl_read = 0; stray_mfc = 0;
    endtask

    function automatic logic [W-1:0] alu_ref(input logic [2:0] op,
                                             input logic [W-1:0] a, input logic [W-1:0] b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return a;
            3'd6: return b;
            default: return '0;
        endcase
    endfunction

    task automatic fetch();
        logic [W-1:0] addr;
        @(negedge clk); idle();
        b_sel = 2'd1; alu_op = 3'd6; mar_load = 1; ctl_read = 1; pc_inc = 1;
        push(K_BUSC, m_pc, "R5 pc onto bus B");
        addr = m_pc; m_pc = m_pc + 16'd4;
        @(negedge clk); idle();
        push(K_PC, m_pc, "R6 pc increment");
        push(K_ADDR, addr, "R7 mar load");
        push(K_REQ, 16'd1, "R8 request raised");
        @(negedge clk); idle();
        push(K_REQ, 16'd1, "R8 request held while waiting");
        @(negedge clk); idle();
        push(K_REQ, 16'd0, "R8 request dropped after completion");
        m_mdr = mem_word(addr);
        b_sel = 2'd2; alu_op = 3'd6; ir_load = 1;
        push(K_BUSC, m_mdr, "R8 mdr captured");
        m_ir = m_mdr;
        @(negedge clk); idle();
        push(K_IR, m_ir, "R9 fetch ends in IR");
    endtask

    task automatic store_mdr(input logic [2:0] d);
        @(negedge clk); idle();
        b_sel = 2'd2; alu_op = 3'd6; rf_we = 1; rf_wa = d;
        push(K_BUSC, m_mdr, "R3 mdr to register");
        m_reg[d] = m_mdr;
    endtask

    task automatic read_reg(input logic [2:0] r, input string tag);
        @(negedge clk); idle();
        rf_ra_a = r; alu_op = 3'd5;
        push(K_BUSC, m_reg[r], tag);
    endtask

    task automatic alu_step(input logic [2:0] op, input logic [2:0] a, input logic [2:0] b,
                            input logic [2:0] d, input logic we, input string tag);
        logic [W-1:0] r;
        @(negedge clk); idle();
        rf_ra_a = a; rf_ra_b = b; b_sel = 2'd0; alu_op = op; rf_wa = d; rf_we = we;
        r = alu_ref(op, m_reg[a], m_reg[b]);
        push(K_BUSC, r, tag);
        if (we) m_reg[d] = r;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        push(K_PC, 16'd0, "R1 pc after reset");
        push(K_IR, 16'd0, "R1 ir after reset");
        push(K_ADDR, 16'd0, "R1 mar after reset");
        push(K_REQ, 16'd0, "R1 no request after reset");
        read_reg(3'd5, "R1 register cleared");

        for (int r = 1; r <= 4; r++) begin
            fetch();
            store_mdr(3'(r));
        end
        for (int r = 1; r <= 4; r++) read_reg(3'(r), "R2 register readback");

        // Every ALU operation, result written to r5 and read back.
        for (int op = 0; op < 8; op++) begin
            alu_step(3'(op), 3'd1, 3'd2, 3'd5, 1'b1, "R4 alu operation");
            read_reg(3'd5, "R4 result stored");
        end
        alu_step(3'd1, 3'd3, 3'd4, 3'd6, 1'b1, "R4 subtract wraps");

        // Two reads in one cycle with destination equal to a source.
        alu_step(3'd0, 3'd1, 3'd2, 3'd1, 1'b1, "R9 one-step add uses old source");
        read_reg(3'd1, "R3 write lands at edge");
        alu_step(3'd0, 3'd3, 3'd3, 3'd3, 1'b0, "R2 same register on both buses");
        read_reg(3'd3, "R3 no write without enable");

        // Bus B zero source.
        @(negedge clk); idle();
        rf_ra_a = 3'd4; b_sel = 2'd3; alu_op = 3'd0;
        push(K_BUSC, m_reg[4], "R5 zero on bus B");

        // PC load wins over increment.
        @(negedge clk); idle();
        rf_ra_a = 3'd4; alu_op = 3'd5; pc_load = 1; pc_inc = 1;
        m_pc = m_reg[4];
        @(negedge clk); idle();
        push(K_PC, m_pc, "R6 load beats increment");
        pc_inc = 1; m_pc = m_pc + 16'd4;
        @(negedge clk); idle();
        push(K_PC, m_pc, "R6 increment alone");

        // Completion with nothing pending must not touch MDR.
        @(negedge clk); idle();
        stray_mfc = 1;
        @(negedge clk); idle();
        b_sel = 2'd2; alu_op = 3'd6;
        push(K_BUSC, m_mdr, "R8 stray completion ignored");
        push(K_REQ, 16'd0, "R8 no request from stray completion");
        push(K_IR, m_ir, "R7 ir holds");

        fetch();
        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule